// File: doc/BRIEF.md
# Status Register Transfer Unit

This block carries out the two status-word move operations of a processor core. It can copy the current status word or the saved status word into a general register. It can also load either status word from a general register or from a rotated 8-bit constant. The block keeps both status words in its own registers. It decodes the relevant fields of a 32-bit instruction word and reads one general register through an external read port. It reports the new status values with one-cycle write pulses, a general-register write (index and data) for the read form, and a fault pulse for any access that is not allowed.

An operation is presented by raising `instrValid` for one cycle, together with `condPass` from the condition evaluator. All results appear on the registered outputs at the next rising edge. A faulting operation changes nothing. The current mode is taken from the low five bits of the held current status word. The core can let User mode change its own mode bits by setting `allowUserModeSwitch`.

Top module: `psrXferUnit`

## Requirements
- R1: After reset both `cpsrOut` and `spsrOut` equal 0x00000013 (Supervisor mode, all flags clear), and all write pulses and `accessFault` are low.
- R2: With instruction bit 21 clear (read form), `gprWrEn` pulses one cycle after the operation, `gprWrIdx` equals instruction bits 15:12, and `gprWrData` holds the saved word if bit 22 is set and the current word if it is clear.
- R3: With bit 21 set, bit 16 set and bit 25 clear (full register write), the target word selected by bit 22 is replaced by `rfRdData`, and `rfRdIdx` always equals instruction bits 3:0.
- R4: With bit 21 set and bit 16 clear (flags-only write), only bits 31:28 of the target take the source value and bits 27:0 keep their previous contents.
- R5: With bit 25 set in a flags-only write, the source is instruction bits 7:0 zero-extended and rotated right by twice the value of bits 11:8.
- R6: A write with both bit 25 and bit 16 set faults, and no register changes.
- R7: A write whose resulting low five bits are not one of 10000, 10001, 10010, 10011, 10111, 11011, 11111 faults, and no register changes.
- R8: Any access (read or write) that selects the saved word while the current mode is 10000 (User) faults, and nothing is written.
- R9: A current-word write from User mode that would change the mode bits faults unless `allowUserModeSwitch` is high. A write that keeps the mode bits is allowed.
- R10: When `instrValid` or `condPass` is low, no write pulse or fault appears on the following cycle and both status words are unchanged.
- R11: Write pulses and `accessFault` last exactly one cycle, aligned with the updated status outputs, and a status word changes only on a cycle where its write pulse is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| instrValid | input | 1 | Operation strobe |
| instrWord | input | 32 | Instruction word |
| condPass | input | 1 | Condition check passed |
| allowUserModeSwitch | input | 1 | Lets User mode change its mode bits |
| rfRdIdx | output | 4 | General-register read index |
| rfRdData | input | 32 | General-register read data |
| cpsrOut | output | 32 | Current status word |
| spsrOut | output | 32 | Saved status word |
| cpsrWrEn | output | 1 | Current word was written |
| spsrWrEn | output | 1 | Saved word was written |
| gprWrEn | output | 1 | General-register write strobe |
| gprWrIdx | output | 4 | General-register write index |
| gprWrData | output | 32 | General-register write data |
| accessFault | output | 1 | Illegal access detected |

## Verification
The embedded properties assume that `instrValid`, `condPass`, `allowUserModeSwitch`, `instrWord` and `rfRdData` carry known values and stay stable around each rising edge. They also assume that the held saved word always carries a legal mode, so that a flags-only update of it can only fault through the User-mode rule. The stimulus changes every input on the falling edge only. It draws the mode bits of the general-register data from the legal set most of the time and occasionally from arbitrary values. The saved word starts legal and can only be written with legal modes, because illegal writes are rejected.

// File: rtl/psrXferPkg.sv
package psrXferPkg;

  localparam int unsigned MODE_W = 5;

  localparam logic [MODE_W-1:0] MODE_USR = 5'b10000;
  localparam logic [MODE_W-1:0] MODE_FIQ = 5'b10001;
  localparam logic [MODE_W-1:0] MODE_IRQ = 5'b10010;
  localparam logic [MODE_W-1:0] MODE_SVC = 5'b10011;
  localparam logic [MODE_W-1:0] MODE_ABT = 5'b10111;
  localparam logic [MODE_W-1:0] MODE_UND = 5'b11011;
  localparam logic [MODE_W-1:0] MODE_SYS = 5'b11111;

  // instruction bit positions the decoder relies on
  localparam int unsigned BIT_IMM   = 25;
  localparam int unsigned BIT_SAVED = 22;
  localparam int unsigned BIT_WRITE = 21;
  localparam int unsigned BIT_FULL  = 16;

  typedef struct packed {
    logic selSpsr;
    logic selImm;
    logic flagsOnly;
    logic cpsrWe;
    logic spsrWe;
    logic gprWe;
    logic fault;
  } xferStrobes_t;

  function automatic logic modeIsLegal(input logic [MODE_W-1:0] m);
    case (m)
      MODE_USR, MODE_FIQ, MODE_IRQ, MODE_SVC,
      MODE_ABT, MODE_UND, MODE_SYS: modeIsLegal = 1'b1;
      default:                      modeIsLegal = 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/psrXferCtrl.sv
module psrXferCtrl
  import psrXferPkg::*;
(
  input  logic              instrValid,
  input  logic              condPass,
  input  logic              allowUserModeSwitch,
  input  logic              isWrite,
  input  logic              savedSel,
  input  logic              immForm,
  input  logic              fullField,
  input  logic [MODE_W-1:0] curMode,
  input  logic [MODE_W-1:0] candMode,
  output xferStrobes_t      strobes
);

  logic execute;
  logic inUser;
  logic badSaved;
  logic badImm;
  logic badMode;
  logic badSwitch;
  logic faultAny;

  always_comb begin
    execute   = instrValid & condPass;
    inUser    = (curMode == MODE_USR);
    badSaved  = savedSel & inUser;
    badImm    = immForm & fullField;
    badMode   = !modeIsLegal(candMode);
    badSwitch = !savedSel & inUser & (candMode != curMode) & !allowUserModeSwitch;
    faultAny  = execute & (badSaved | (isWrite & (badImm | badMode | badSwitch)));

    strobes.selSpsr   = savedSel;
    strobes.selImm    = immForm;
    strobes.flagsOnly = !fullField;
    strobes.fault     = faultAny;
    strobes.cpsrWe    = execute & isWrite & !savedSel & !faultAny;
    strobes.spsrWe    = execute & isWrite &  savedSel & !faultAny;
    strobes.gprWe     = execute & !isWrite & !faultAny;
  end

endmodule

// File: rtl/psrXferDatapath.sv
module psrXferDatapath
  import psrXferPkg::*;
#(
  parameter int unsigned PSR_W   = 32,
  parameter int unsigned IDX_W   = 4,
  parameter int unsigned IMM_W   = 8,
  parameter int unsigned ROT_W   = 4,
  parameter int unsigned FLAG_W  = 4,
  parameter logic [PSR_W-1:0] RESET_PSR = 32'h0000_0013
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              instrValid,
  input  logic              condPass,
  input  xferStrobes_t      strobes,
  input  logic [IMM_W-1:0]  immField,
  input  logic [ROT_W-1:0]  rotField,
  input  logic [IDX_W-1:0]  dstIdx,
  input  logic [PSR_W-1:0]  rfRdData,
  output logic [MODE_W-1:0] candMode,
  output logic [PSR_W-1:0]  cpsrQ,
  output logic [PSR_W-1:0]  spsrQ,
  output logic              cpsrWrEn,
  output logic              spsrWrEn,
  output logic              gprWrEn,
  output logic [IDX_W-1:0]  gprWrIdx,
  output logic [PSR_W-1:0]  gprWrData,
  output logic              accessFault
);

  localparam int unsigned SH_W     = $clog2(PSR_W);
  localparam int unsigned KEEP_W   = PSR_W - FLAG_W;

  logic [PSR_W-1:0]   immWide;
  logic [2*PSR_W-1:0] rotPair;
  logic [SH_W-1:0]    rotAmt;
  logic [PSR_W-1:0]   rotImm;
  logic [PSR_W-1:0]   srcVal;
  logic [PSR_W-1:0]   targetQ;
  logic [PSR_W-1:0]   candVal;

  always_comb begin
    immWide = {{(PSR_W-IMM_W){1'b0}}, immField};
    rotAmt  = SH_W'({rotField, 1'b0});
    rotPair = {immWide, immWide} >> rotAmt;
    rotImm  = rotPair[PSR_W-1:0];
    srcVal  = strobes.selImm ? rotImm : rfRdData;
    targetQ = strobes.selSpsr ? spsrQ : cpsrQ;
    candVal = strobes.flagsOnly ? {srcVal[PSR_W-1:KEEP_W], targetQ[KEEP_W-1:0]} : srcVal;
    candMode = candVal[MODE_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cpsrQ       <= RESET_PSR;
      spsrQ       <= RESET_PSR;
      cpsrWrEn    <= 1'b0;
      spsrWrEn    <= 1'b0;
      gprWrEn     <= 1'b0;
      accessFault <= 1'b0;
      gprWrIdx    <= '0;
      gprWrData   <= '0;
    end else begin
      cpsrWrEn    <= strobes.cpsrWe;
      spsrWrEn    <= strobes.spsrWe;
      gprWrEn     <= strobes.gprWe;
      accessFault <= strobes.fault;
      if (strobes.cpsrWe) cpsrQ <= candVal;
      if (strobes.spsrWe) spsrQ <= candVal;
      if (strobes.gprWe) begin
        gprWrIdx  <= dstIdx;
        gprWrData <= targetQ;
      end
    end
  end

  // R10
  idle_no_effect_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(instrValid && condPass) |=> !cpsrWrEn && !spsrWrEn && !gprWrEn && !accessFault);

  // R7
  cpsr_mode_legal_chk: assert property (@(posedge clk) disable iff (!rstN)
    cpsrWrEn |-> modeIsLegal(cpsrQ[MODE_W-1:0]));

  // R7
  spsr_mode_legal_chk: assert property (@(posedge clk) disable iff (!rstN)
    spsrWrEn |-> modeIsLegal(spsrQ[MODE_W-1:0]));

  // R8
  user_saved_chk: assert property (@(posedge clk) disable iff (!rstN)
    (spsrWrEn || gprWrEn) |-> !(gprWrEn && gprWrData == spsrQ && $past(strobes.selSpsr)
                                && $past(cpsrQ[MODE_W-1:0]) == MODE_USR)
                              && !(spsrWrEn && $past(cpsrQ[MODE_W-1:0]) == MODE_USR));

  // R6
  fault_blocks_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    accessFault |-> !cpsrWrEn && !spsrWrEn && !gprWrEn);

  // R11
  cpsr_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !cpsrWrEn |-> $stable(cpsrQ));

  // R11
  spsr_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !spsrWrEn |-> $stable(spsrQ));

endmodule

// File: rtl/psrXferUnit.sv
module psrXferUnit
  import psrXferPkg::*;
#(
  parameter int unsigned PSR_W = 32,
  parameter int unsigned IDX_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              instrValid,
  input  logic [31:0]       instrWord,
  input  logic              condPass,
  input  logic              allowUserModeSwitch,
  output logic [IDX_W-1:0]  rfRdIdx,
  input  logic [PSR_W-1:0]  rfRdData,
  output logic [PSR_W-1:0]  cpsrOut,
  output logic [PSR_W-1:0]  spsrOut,
  output logic              cpsrWrEn,
  output logic              spsrWrEn,
  output logic              gprWrEn,
  output logic [IDX_W-1:0]  gprWrIdx,
  output logic [PSR_W-1:0]  gprWrData,
  output logic              accessFault
);

  localparam int unsigned IMM_W = 8;
  localparam int unsigned ROT_W = 4;
  localparam int unsigned RD_LSB = 12;
  localparam int unsigned ROT_LSB = 8;

  xferStrobes_t     strobes;
  logic [MODE_W-1:0] candMode;
  logic             unusedInstrBits;

  assign unusedInstrBits = ^{instrWord[31:26], instrWord[24:23], instrWord[20:17]};
  assign rfRdIdx = instrWord[IDX_W-1:0];

  psrXferCtrl ctrl_i (
    .instrValid          (instrValid),
    .condPass            (condPass),
    .allowUserModeSwitch (allowUserModeSwitch),
    .isWrite             (instrWord[BIT_WRITE]),
    .savedSel            (instrWord[BIT_SAVED]),
    .immForm             (instrWord[BIT_IMM]),
    .fullField           (instrWord[BIT_FULL]),
    .curMode             (cpsrOut[MODE_W-1:0]),
    .candMode            (candMode),
    .strobes             (strobes)
  );

  psrXferDatapath #(
    .PSR_W (PSR_W),
    .IDX_W (IDX_W),
    .IMM_W (IMM_W),
    .ROT_W (ROT_W)
  ) dp_i (
    .clk         (clk),
    .rstN        (rstN),
    .instrValid  (instrValid),
    .condPass    (condPass),
    .strobes     (strobes),
    .immField    (instrWord[IMM_W-1:0]),
    .rotField    (instrWord[ROT_LSB +: ROT_W]),
    .dstIdx      (instrWord[RD_LSB +: IDX_W]),
    .rfRdData    (rfRdData),
    .candMode    (candMode),
    .cpsrQ       (cpsrOut),
    .spsrQ       (spsrOut),
    .cpsrWrEn    (cpsrWrEn),
    .spsrWrEn    (spsrWrEn),
    .gprWrEn     (gprWrEn),
    .gprWrIdx    (gprWrIdx),
    .gprWrData   (gprWrData),
    .accessFault (accessFault)
  );

endmodule

// File: tb/psrXferUnit_tb_top.sv
module psrXferUnit_tb_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        instrValid = 1'b0;
  logic [31:0] instrWord = '0;
  logic        condPass = 1'b0;
  logic        allowUserModeSwitch = 1'b0;
  logic [3:0]  rfRdIdx;
  logic [31:0] rfRdData = '0;
  logic [31:0] cpsrOut, spsrOut, gprWrData;
  logic        cpsrWrEn, spsrWrEn, gprWrEn, accessFault;
  logic [3:0]  gprWrIdx;

  int total = 0;
  int bad = 0;
  logic [31:0] cpsrM, spsrM;

  localparam logic [4:0] LEGAL [7] = '{5'b10000, 5'b10001, 5'b10010, 5'b10011,
                                      5'b10111, 5'b11011, 5'b11111};

  always #4 clk = ~clk;

  psrXferUnit dut_i (
    .clk(clk), .rstN(rstN), .instrValid(instrValid), .instrWord(instrWord),
    .condPass(condPass), .allowUserModeSwitch(allowUserModeSwitch),
    .rfRdIdx(rfRdIdx), .rfRdData(rfRdData), .cpsrOut(cpsrOut), .spsrOut(spsrOut),
    .cpsrWrEn(cpsrWrEn), .spsrWrEn(spsrWrEn), .gprWrEn(gprWrEn),
    .gprWrIdx(gprWrIdx), .gprWrData(gprWrData), .accessFault(accessFault)
  );

  function automatic logic [31:0] mk(input logic sv, input logic wr, input logic full,
                                     input logic im, input logic [3:0] rd,
                                     input logic [3:0] rot, input logic [7:0] imm8);
    mk = {4'hE, 2'b00, im, 2'b10, sv, wr, 4'b1001, full, rd, rot, imm8};
  endfunction

  function automatic logic legal(input logic [4:0] m);
    legal = 1'b0;
    for (int i = 0; i < 7; i++) if (LEGAL[i] == m) legal = 1'b1;
  endfunction

  function automatic logic [31:0] rotr(input logic [31:0] v, input int n);
    logic [31:0] t = v;
    for (int i = 0; i < n; i++) t = {t[0], t[31:1]};
    rotr = t;
  endfunction

  task automatic check(input string tag, input logic ok, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // one operation: drive at falling edge, compare after the next rising edge
  task automatic op(input logic [31:0] ins, input logic cond, input logic vld,
                    input logic allow, input logic [31:0] rf);
    logic eC, eS, eG, eF;
    logic [31:0] nC, nS, eData, src, nv;
    string tag;
    logic user;
    instrWord = ins; condPass = cond; instrValid = vld;
    allowUserModeSwitch = allow; rfRdData = rf;
    #1;
    check("R3 read index", rfRdIdx == ins[3:0], {60'd0, rfRdIdx}, {60'd0, ins[3:0]});
    eC = 0; eS = 0; eG = 0; eF = 0; nC = cpsrM; nS = spsrM; eData = '0;
    user = (cpsrM[4:0] == 5'b10000);
    tag = "R10";
    if (vld && cond) begin
      if (ins[22] && user) begin
        eF = 1; tag = "R8";
      end else if (!ins[21]) begin
        eG = 1; eData = ins[22] ? spsrM : cpsrM; tag = "R2";
      end else if (ins[25] && ins[16]) begin
        eF = 1; tag = "R6";
      end else begin
        src = ins[25] ? rotr({24'd0, ins[7:0]}, 2 * ins[11:8]) : rf;
        if (!ins[16]) begin
          nv = {src[31:28], (ins[22] ? spsrM[27:0] : cpsrM[27:0])};
          tag = ins[25] ? "R5" : "R4";
        end else begin
          nv = src; tag = "R3";
        end
        if (!legal(nv[4:0])) begin
          eF = 1; tag = "R7";
        end else if (!ins[22] && user && nv[4:0] != cpsrM[4:0] && !allow) begin
          eF = 1; tag = "R9";
        end else if (ins[22]) begin
          eS = 1; nS = nv;
        end else begin
          eC = 1; nC = nv;
          if (user) tag = "R9";
        end
      end
    end
    @(posedge clk);
    @(negedge clk);
    check({tag, " status words"}, cpsrOut == nC && spsrOut == nS,
          {cpsrOut, spsrOut}, {nC, nS});
    check({tag, " strobes"}, {cpsrWrEn, spsrWrEn, gprWrEn, accessFault} == {eC, eS, eG, eF},
          {60'd0, cpsrWrEn, spsrWrEn, gprWrEn, accessFault}, {60'd0, eC, eS, eG, eF});
    if (eG)
      check({tag, " gpr write"}, gprWrIdx == ins[15:12] && gprWrData == eData,
            {28'd0, gprWrIdx, gprWrData}, {28'd0, ins[15:12], eData});
    cpsrM = nC; spsrM = nS;
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : main
    logic [31:0] r;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    cpsrM = 32'h13; spsrM = 32'h13;
    // R1 reset state
    check("R1 reset words", cpsrOut == 32'h13 && spsrOut == 32'h13,
          {cpsrOut, spsrOut}, {32'h13, 32'h13});
    check("R1 reset strobes", {cpsrWrEn, spsrWrEn, gprWrEn, accessFault} == 4'b0,
          {60'd0, cpsrWrEn, spsrWrEn, gprWrEn, accessFault}, 64'd0);

    // directed corner cases
    op(mk(0, 0, 1, 0, 4'd7, 0, 0), 1, 1, 0, 0);                      // R2 read current
    op(mk(1, 1, 1, 0, 0, 0, 8'h03), 1, 1, 0, 32'hA000_0011);         // R3 saved <- FIQ
    op(mk(1, 0, 1, 0, 4'd9, 0, 0), 1, 1, 0, 0);                      // R2 read saved
    op(mk(0, 1, 0, 1, 0, 4'd2, 8'h0F), 1, 1, 0, 0);                  // R5 flags from rotated imm
    op(mk(0, 1, 0, 1, 0, 4'd0, 8'hF0), 1, 1, 0, 0);                  // R5 rot 0, flags clear
    op(mk(0, 1, 0, 0, 4'd5, 0, 8'h02), 1, 1, 0, 32'h5FFF_FFE0);      // R4 flags-only reg
    op(mk(0, 1, 1, 1, 0, 4'd1, 8'h13), 1, 1, 0, 0);                  // R6 imm with full field
    op(mk(0, 1, 1, 0, 0, 0, 8'h04), 1, 1, 0, 32'h0000_0015);         // R7 illegal mode
    op(mk(0, 1, 1, 0, 0, 0, 8'h04), 0, 1, 0, 32'h0000_0010);         // R10 cond fails
    op(mk(0, 1, 1, 0, 0, 0, 8'h04), 1, 0, 0, 32'h0000_0010);         // R10 not valid
    op(mk(0, 1, 1, 0, 0, 0, 8'h04), 1, 1, 0, 32'h8000_0010);         // R3 enter User
    op(mk(1, 0, 1, 0, 4'd2, 0, 0), 1, 1, 0, 0);                      // R8 read saved in User
    op(mk(1, 1, 1, 0, 0, 0, 0), 1, 1, 1, 32'h0000_0013);             // R8 write saved in User
    op(mk(0, 1, 1, 0, 0, 0, 0), 1, 1, 0, 32'h0000_0011);             // R9 blocked switch
    op(mk(0, 1, 1, 0, 0, 0, 0), 1, 1, 0, 32'h4000_0010);             // R9 same mode ok
    op(mk(0, 1, 1, 0, 0, 0, 0), 1, 1, 1, 32'h0000_0012);             // R9 switch allowed
    op(mk(0, 0, 1, 0, 4'd15, 0, 0), 1, 1, 0, 0);                     // R11 pulse then idle
    op(0, 0, 0, 0, 0);                                               // R11 idle after pulse

    // constrained random
    for (int n = 0; n < 600; n++) begin
      r = $urandom();
      if (($urandom() % 10) != 0) r[4:0] = LEGAL[$urandom() % 7];
      op(mk(1'($urandom()), 1'($urandom()), 1'($urandom()), ($urandom() % 4) == 0,
            4'($urandom()), 4'($urandom()), 8'($urandom())),
         ($urandom() % 5) != 0, ($urandom() % 5) != 0, 1'($urandom()), r);
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule